// File: doc/BRIEF.md
# Lockout Nibble Stream Mixer

This block models the handshake side of a cartridge lockout chip. It keeps two 15-nibble states. The local state is the stream the block sends. The expected state is the stream the partner chip is predicted to send. Both states are advanced by the same nibble-arithmetic recurrence. The recurrence takes a data-dependent path through the nibbles and runs for a data-dependent number of iterations.

A session begins with a pulse on `start`. The block first sends four stream-select bits taken from nibble 1 of the expected seed. After that it runs rounds of bit slots. In each slot the block sends bit 0 of one local nibble and samples the partner's bit. It compares the sampled bit with bit 0 of the matching expected nibble. Any difference sets a sticky mismatch flag. During the very first round, the bit received at nibble 2 identifies the partner type, and the block writes the matching constant into expected nibble 2.

Between rounds both states are mixed three times. Nibble 7 of the expected state then sets two things: the data-line swap flag and the nibble at which the next round starts. One bit slot lasts one clock, so the timing is not cycle-exact to real silicon.

Top module: `lockout_stream_engine`

## Requirements
- R1: After synchronous reset, all outputs are 0 (`tx_bit`, `bit_strobe`, `sel_phase`, `line_swap`, `mismatch`). They stay 0 until `start` is seen.
- R2: The clock edge that samples `start` begins four consecutive slots. In these slots `bit_strobe` and `sel_phase` are both 1. `tx_bit` carries bits 3, 0, 1, 2 of expected-seed nibble 1, in that order. `rx_bit` is ignored in these slots.
- R3: An exchange round is a run of consecutive slots with `bit_strobe`=1 and `sel_phase`=0, one slot per nibble from the start index up to nibble 15. Each slot shows bit 0 of that local nibble on `tx_bit`. The first round starts at nibble 1. The local state does not change during a round.
- R4: In an exchange slot, `rx_bit` is sampled at the clock edge that ends the slot and compared with bit 0 of the expected nibble. A difference sets `mismatch` from the next cycle on. Only reset or `start` clears `mismatch`.
- R5: In the nibble-2 slot of the first round, `rx_bit`=1 writes 9 into expected nibble 2 and `rx_bit`=0 writes 6. That slot never sets `mismatch`. The seed value of expected nibble 2 has no effect.
- R6: A pass of the mixing recurrence runs s15+1 iterations, where s15 is the value of nibble 15 at the start of the pass. The loop counter c counts down from s15 to 0. One iteration, with all arithmetic modulo 16, does this:
  - s1 += c+1.
  - s2 = ~(old s2 + s1 + 1).
  - t = old s2 + s3 + 1.
  - If t < 16: s3 = t, s4 += old s3, then the pivot step runs at p = 5.
  - Otherwise: s3 = t + old s3, then the pivot step runs at p = 4.
  - Pivot step: s[p] += s[p-1]; if old s[p] >= 8 then s[p+1] = old s[p] + 8, else s[p+1] += old s[p] + 8; then s[p+2] += old s[p+1] + 1.
  - Every later nibble up to 15 then adds its new predecessor plus 1.
- R7: After each round both states go through three passes of R6. When the next round begins, `line_swap` equals bit 0 of expected nibble 7. It does not change at any other time except at `start`.
- R8: The next round starts at nibble k, where k is the value of expected nibble 7 after mixing. If k is 0, the round starts at nibble 1.
- R9: Between rounds `bit_strobe` is 0 for exactly max(Nl, Nk)+2 cycles. Nl and Nk are the total iteration counts of the three local passes and the three expected passes.
- R10: `start` in any state, including during mixing, reloads both seeds, clears `mismatch` and `line_swap`, and begins a new select phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new session (loads both seeds) |
| lock_seed | input | 60 | Local seed; nibble i sits at bits [4i-1:4i-4] |
| key_seed | input | 60 | Expected seed, same layout; nibble 2 is replaced by detection |
| rx_bit | input | 1 | Bit received from the partner in the current slot |
| tx_bit | output | 1 | Bit sent in the current slot |
| bit_strobe | output | 1 | High during every select or exchange slot |
| sel_phase | output | 1 | High during the four stream-select slots |
| line_swap | output | 1 | Data-line direction flag for the external pin multiplexer |
| mismatch | output | 1 | Sticky flag: a received bit differed from the expected stream |

## Verification
Two things happen at the same clock edge in the nibble-2 slot of the first round. The partner-type detection rewrites expected nibble 2, and the slot's received bit is available for comparison. The bench provokes this by running sessions with both partner types. It then checks that `mismatch` stays clear and that the later rounds follow the stream implied by the detected constant. A second overlap is the end of mixing, when the two mixers finish in different cycles or in the same cycle. Every per-cycle comparison checks that the idle gap length follows the slower of the two. A restart that lands in the middle of mixing is also checked.

// File: rtl/lockmix_pkg.sv
package lockmix_pkg;
  localparam int NIB_W   = 4;
  localparam int NIBS    = 15;
  localparam int STATE_W = NIB_W * NIBS;

  typedef logic [NIB_W-1:0]         nib_t;
  typedef logic [NIBS:1][NIB_W-1:0] nstate_t;

  localparam nib_t KEY_NTSC = 4'h9;
  localparam nib_t KEY_PAL  = 4'h6;

  typedef enum logic [1:0] {S_IDLE, S_SEL, S_XCH, S_MIX} seq_t;

  // One iteration of the mixing recurrence with loop counter c.
  function automatic nstate_t mix_step(nstate_t s_in, nib_t c);
    nstate_t s;
    nib_t o2, o3, ox, oy;
    logic [NIB_W:0] t;
    logic sk;
    s = s_in;
    s[1] = s[1] + c + 1'b1;
    o2 = s[2];
    s[2] = ~(o2 + s[1] + 1'b1);
    o3 = s[3];
    t = {1'b0, o2} + {1'b0, o3} + 1'b1;
    sk = t[NIB_W];
    if (sk) begin
      s[3] = t[NIB_W-1:0] + o3;
      ox = s[4];
      s[4] = s[4] + s[3];
      oy = s[5];
      s[5] = ox[NIB_W-1] ? ox + 4'd8 : oy + ox + 4'd8;
      s[6] = s[6] + oy + 1'b1;
    end else begin
      s[3] = t[NIB_W-1:0];
      s[4] = s[4] + o3;
      ox = s[5];
      s[5] = s[5] + s[4];
      oy = s[6];
      s[6] = ox[NIB_W-1] ? ox + 4'd8 : oy + ox + 4'd8;
      s[7] = s[7] + oy + 1'b1;
    end
    for (int k = 7; k <= NIBS; k++) begin
      if (k != 7 || sk) s[k] = s[k] + s[k-1] + 1'b1;
    end
    return s;
  endfunction
endpackage

// File: rtl/nibble_mixer.sv
module nibble_mixer
  import lockmix_pkg::*;
#(
  parameter int PASSES = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  nstate_t seed,
  input  logic    start,
  input  logic    patch_en,
  input  nib_t    patch_val,
  output nstate_t state,
  output logic    busy,
  output logic    done
);
  localparam int PW = (PASSES > 1) ? $clog2(PASSES) : 1;

  nib_t          cnt;
  logic [PW-1:0] pass;
  nstate_t       nxt;

  always_comb nxt = mix_step(state, cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      pass  <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        state <= seed;
        busy  <= 1'b0;
      end else if (start) begin
        busy <= 1'b1;
        cnt  <= state[NIBS];
        pass <= '0;
      end else if (busy) begin
        state <= nxt;
        if (cnt == '0) begin
          if (pass == PW'(PASSES - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            pass <= pass + 1'b1;
            cnt  <= nxt[NIBS];
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (patch_en) begin
        state[2] <= patch_val;
      end
    end
  end

  // R6: completion follows a busy period and lasts one cycle
  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/xchg_sequencer.sv
module xchg_sequencer
  import lockmix_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    sel_msb,
  input  nstate_t lock_st,
  input  nstate_t key_st,
  input  logic    done_l,
  input  logic    done_k,
  input  logic    rx_bit,
  output logic    tx_bit,
  output logic    bit_strobe,
  output logic    sel_phase,
  output logic    line_swap,
  output logic    mismatch,
  output logic    mix_start,
  output logic    patch_en,
  output nib_t    patch_val
);
  seq_t       seq;
  nib_t       slot;
  logic       first, got_l, got_k;
  nib_t       nxt_slot, k7, s0;
  logic [1:0] sel_j, sel_b;

  assign nxt_slot = slot + 1'b1;
  assign k7       = key_st[7];
  assign s0       = (k7 == '0) ? nib_t'(1) : k7;
  assign sel_j    = slot[1:0] + 2'd1;
  assign sel_b    = (sel_j == 2'd0) ? 2'd3 : sel_j - 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq <= S_IDLE; slot <= '0; first <= 1'b0;
      got_l <= 1'b0; got_k <= 1'b0;
      tx_bit <= 1'b0; bit_strobe <= 1'b0; sel_phase <= 1'b0;
      line_swap <= 1'b0; mismatch <= 1'b0;
      mix_start <= 1'b0; patch_en <= 1'b0; patch_val <= '0;
    end else begin
      mix_start <= 1'b0;
      patch_en  <= 1'b0;
      if (start) begin
        seq <= S_SEL; slot <= '0; first <= 1'b1;
        bit_strobe <= 1'b1; sel_phase <= 1'b1; tx_bit <= sel_msb;
        mismatch <= 1'b0; line_swap <= 1'b0;
      end else begin
        case (seq)
          S_SEL: begin
            if (slot == 4'd3) begin
              seq <= S_XCH; slot <= 4'd1; sel_phase <= 1'b0;
              tx_bit <= lock_st[1][0];
            end else begin
              slot <= nxt_slot;
              tx_bit <= key_st[1][sel_b];
            end
          end
          S_XCH: begin
            if (first && slot == 4'd2) begin
              patch_en  <= 1'b1;
              patch_val <= rx_bit ? KEY_NTSC : KEY_PAL;
            end else if (rx_bit != key_st[slot][0]) begin
              mismatch <= 1'b1;
            end
            if (slot == nib_t'(NIBS)) begin
              seq <= S_MIX; bit_strobe <= 1'b0; tx_bit <= 1'b0;
              mix_start <= 1'b1; first <= 1'b0;
              got_l <= 1'b0; got_k <= 1'b0;
            end else begin
              slot <= nxt_slot;
              tx_bit <= lock_st[nxt_slot][0];
            end
          end
          S_MIX: begin
            if (done_l) got_l <= 1'b1;
            if (done_k) got_k <= 1'b1;
            if ((got_l || done_l) && (got_k || done_k)) begin
              seq <= S_XCH; bit_strobe <= 1'b1;
              line_swap <= k7[0];
              slot <= s0;
              tx_bit <= lock_st[s0][0];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_sel_in_slot_R2: assert property (@(posedge clk) disable iff (rst)
    sel_phase |-> bit_strobe);
  assert_mismatch_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    mismatch && !start |=> mismatch);
  assert_swap_only_after_mix_R7: assert property (@(posedge clk) disable iff (rst)
    (seq != S_MIX) && !start |=> $stable(line_swap));
  assert_lock_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (seq == S_XCH) && !start |=> $stable(lock_st));
  assert_key_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (seq == S_XCH) && !start && !patch_en |=> $stable(key_st));
endmodule

// File: rtl/lockout_stream_engine.sv
module lockout_stream_engine
  import lockmix_pkg::*;
#(
  parameter int MIX_PASSES = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [STATE_W-1:0] lock_seed,
  input  logic [STATE_W-1:0] key_seed,
  input  logic               rx_bit,
  output logic               tx_bit,
  output logic               bit_strobe,
  output logic               sel_phase,
  output logic               line_swap,
  output logic               mismatch
);
  nstate_t seed_a [2];
  nstate_t st_a   [2];
  logic    busy_a [2];
  logic    done_a [2];
  logic    pen_a  [2];
  nib_t    pval_a [2];
  logic    mix_start, patch_en;
  nib_t    patch_val;

  assign seed_a[0] = lock_seed;
  assign seed_a[1] = key_seed;
  assign pen_a[0]  = 1'b0;
  assign pval_a[0] = '0;
  assign pen_a[1]  = patch_en;
  assign pval_a[1] = patch_val;

  for (genvar g = 0; g < 2; g++) begin : g_mix
    nibble_mixer #(.PASSES(MIX_PASSES)) u_mix (
      .clk       (clk),
      .rst       (rst),
      .load      (start),
      .seed      (seed_a[g]),
      .start     (mix_start),
      .patch_en  (pen_a[g]),
      .patch_val (pval_a[g]),
      .state     (st_a[g]),
      .busy      (busy_a[g]),
      .done      (done_a[g])
    );
  end

  xchg_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .sel_msb    (key_seed[3]),
    .lock_st    (st_a[0]),
    .key_st     (st_a[1]),
    .done_l     (done_a[0]),
    .done_k     (done_a[1]),
    .rx_bit     (rx_bit),
    .tx_bit     (tx_bit),
    .bit_strobe (bit_strobe),
    .sel_phase  (sel_phase),
    .line_swap  (line_swap),
    .mismatch   (mismatch),
    .mix_start  (mix_start),
    .patch_en   (patch_en),
    .patch_val  (patch_val)
  );

  assert_mix_from_idle_R6: assert property (@(posedge clk) disable iff (rst)
    mix_start |-> !busy_a[0] && !busy_a[1]);
endmodule

// File: tb/tb_lockout_stream_engine.sv
module tb_lockout_stream_engine;
  import lockmix_pkg::*;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, rx_bit = 1'b0;
  logic [STATE_W-1:0] lock_seed = '0, key_seed = '0;
  logic tx_bit, bit_strobe, sel_phase, line_swap, mismatch;
  int checks = 0, errors = 0, zero_restarts = 0;
  string cur_tag = "init";

  always #5 clk = ~clk;

  lockout_stream_engine dut (
    .clk(clk), .rst(rst), .start(start), .lock_seed(lock_seed),
    .key_seed(key_seed), .rx_bit(rx_bit), .tx_bit(tx_bit),
    .bit_strobe(bit_strobe), .sel_phase(sel_phase),
    .line_swap(line_swap), .mismatch(mismatch));

  typedef struct { bit stb; bit sel; bit tx; bit mm; bit swp; bit rx; } slot_t;
  slot_t q[$];
  int L[16], K[16];

  // Behavioural model of one mixing pass; returns its iteration count
  function automatic int mix_pass(inout int s[16]);
    int c = s[15];
    int n = 0;
    while (1) begin
      int a2, a3, t, p, o, o2;
      s[1] = (s[1] + c + 1) % 16;
      a2 = s[2];
      s[2] = 15 - ((a2 + s[1] + 1) % 16);
      a3 = s[3];
      t = a2 + a3 + 1;
      if (t >= 16) begin s[3] = (t + a3) % 16; p = 4; end
      else begin s[3] = t; s[4] = (s[4] + a3) % 16; p = 5; end
      o = s[p];
      s[p] = (s[p] + s[p-1]) % 16;
      o2 = s[p+1];
      s[p+1] = (o >= 8) ? o - 8 : (o2 + o + 8) % 16;
      s[p+2] = (s[p+2] + o2 + 1) % 16;
      for (int k = p + 3; k <= 15; k++) s[k] = (s[k] + s[k-1] + 1) % 16;
      n++;
      if (c == 0) break;
      c--;
    end
    return n;
  endfunction

  task automatic push(bit stb, bit sel, bit tx, bit mm, bit swp, bit rx);
    slot_t e;
    e.stb = stb; e.sel = sel; e.tx = tx; e.mm = mm; e.swp = swp; e.rx = rx;
    q.push_back(e);
  endtask

  task automatic load_model(bit custom);
    if (!custom) begin
      L = '{0, 11, 1, 4, 15, 4, 11, 5, 7, 15, 13, 6, 1, 14, 9, 8};
      K = '{0, 15, 0, 10, 1, 8, 5, 15, 1, 1, 14, 1, 0, 13, 14, 12};
    end else begin
      for (int i = 0; i < 16; i++) begin L[i] = (i * 3 + 1) % 16; K[i] = (i * 5 + 2) % 16; end
      K[2] = 3;  // R5: seed value of nibble 2 must not matter
    end
    for (int i = 1; i <= 15; i++) begin
      lock_seed[4*(i-1) +: 4] = 4'(L[i]);
      key_seed[4*(i-1) +: 4]  = 4'(K[i]);
    end
  endtask

  // Builds the per-cycle expected trace starting with the cycle after the start edge
  task automatic build(int rounds, bit pal, int flip_round, int flip_slot);
    int s0 = 1;
    bit mm = 0, swp = 0;
    q.delete();
    for (int j = 0; j < 4; j++) begin
      int b = (j == 0) ? 3 : j - 1;
      push(1, 1, bit'((K[1] >> b) & 1), 0, 0, bit'(j % 2));  // R2
    end
    for (int r = 0; r < rounds; r++) begin
      int nl = 0, nk = 0, idle;
      for (int n = s0; n <= 15; n++) begin
        bit rx;
        if (r == 0 && n == 2) rx = !pal;
        else rx = bit'(K[n] & 1) ^ bit'(r == flip_round && n == flip_slot);
        push(1, 0, bit'(L[n] & 1), mm, swp, rx);
        if (r == 0 && n == 2) K[2] = pal ? 6 : 9;  // R5
        else if (rx != bit'(K[n] & 1)) mm = 1;     // R4
      end
      for (int p = 0; p < 3; p++) begin nl += mix_pass(L); nk += mix_pass(K); end
      idle = ((nl > nk) ? nl : nk) + 2;            // R9
      for (int i = 0; i < idle; i++) push(0, 0, 0, mm, swp, bit'(i % 2));
      swp = bit'(K[7] & 1);                        // R7
      if (K[7] == 0) zero_restarts++;
      s0 = (K[7] == 0) ? 1 : K[7];                 // R8
    end
  endtask

  task automatic chk(logic act, bit exp, string what, int cyc);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] cycle %0d: actual %0b expected %0b", what, cur_tag, cyc, act, exp);
    end
  endtask

  task automatic run(int n_cyc);
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    for (int k = 0; k < n_cyc && k < q.size(); k++) begin
      rx_bit = q[k].rx;
      @(negedge clk);
      chk(bit_strobe, q[k].stb, "R9 strobe", k);
      chk(sel_phase, q[k].sel, "R2 select phase", k);
      chk(tx_bit, q[k].tx, q[k].sel ? "R2 select bit" : "R3 R6 R8 tx bit", k);
      chk(mismatch, q[k].mm, "R4 R5 mismatch", k);
      chk(line_swap, q[k].swp, "R7 swap", k);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cur_tag = "R1 reset";
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      rx_bit = bit'(i % 2);
      @(negedge clk);
      chk(bit_strobe, 0, "R1 strobe", i);
      chk(sel_phase, 0, "R1 select", i);
      chk(tx_bit, 0, "R1 tx", i);
      chk(mismatch, 0, "R1 mismatch", i);
      chk(line_swap, 0, "R1 swap", i);
    end

    cur_tag = "default seeds, type-9 partner";
    load_model(0); build(6, 0, -1, 0); run(q.size());

    cur_tag = "default seeds, type-6 partner";
    load_model(0); build(6, 1, -1, 0); run(q.size());

    cur_tag = "custom seeds, flipped bit at round 1 nibble 15";
    load_model(1); build(5, 0, 1, 15); run(q.size());

    cur_tag = "R10 restart during mixing";
    load_model(0); build(2, 0, 0, 7); run(30);

    cur_tag = "R10 session after restart";
    load_model(1); build(5, 1, -1, 0); run(q.size());

    $display("rounds restarting at nibble 1 after a zero nibble 7: %0d", zero_restarts);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule